// File: doc/BRIEF.md
# BCD Calendar Clock with Write-to-Start

This block keeps wall-clock time and calendar date as packed BCD bytes. The fields are seconds, minutes, hours, day of week, date, month and a two-digit year. It advances once per second. A 32.768 kHz reference enable drives an internal prescaler, and the prescaler makes the one-second tick. The date rolls over at the correct point for 30-day months and for February, and February gains its 29th day in leap years. A plain input selects either a 24-hour hour byte or a 12-hour hour byte that carries a PM flag.

Software loads any field through a byte-wide write strobe. The strobe is accepted on every cycle it is high, so there is no back-pressure. No data stream enters or leaves the block: all pins are plain control or status signals.

When both supplies are lost, the `power_lost` input raises the `clk_fail` flag and stops counting. Reset behaves the same way, because it stands for power-up after a total loss. Counting resumes only after software writes at least one clock field. That write also clears the flag. A write to the seconds field restarts the sub-second prescaler, so the following tick comes one full second after the write.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00, day of week 0, date 01, month 01 and year 00. `clk_fail` is 1 and no field advances.
- R2: A cycle with `power_lost` high sets `clk_fail` on the next cycle and ignores any write in that cycle. While `clk_fail` is 1 every field holds its value.
- R3: A write with `wr_addr` 0..6 loads seconds (0), minutes (1), hour (2), day of week (3), date (4), month (5) or year (6). The value appears on the next cycle, masked to 7, 7, 6, 3, 6, 5 and 8 bits. The write also clears `clk_fail`. Address 7 has no effect and leaves `clk_fail` unchanged.
- R4: While running, the time advances by one second on every REF_DIV-th `ref_en` pulse. A seconds write resets that count, so the next advance comes REF_DIV pulses after the write.
- R5: Seconds and minutes count 00..59 in BCD. Each wraps to 00 and carries into the next field.
- R6: With `mode_12h` = 0, the hour byte counts 00..23 in BCD. Going from 23 to 00 carries into the day.
- R7: With `mode_12h` = 1, bit 5 of the hour byte is PM and bits 4:0 hold 01..12 in BCD. 11 steps to 12 and toggles PM, and 12 steps to 01. Going from 11 PM to 12 AM (byte 0x31 to 0x12) carries into the day.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R9: In February the date wraps after 29 when the year is a multiple of 4 (00, 04 .. 96), and after 28 otherwise.
- R10: Day of week steps 0..6 and wraps to 0 on the same tick that advances the date. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R11: In a cycle with an accepted field write, no field advances, even if the prescaler reaches its terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| power_lost | input | 1 | Pulse indicating both supplies were lost |
| mode_12h | input | 1 | 1 selects 12-hour hour byte with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD byte to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD (bit 5 PM in 12-hour mode) |
| dow_o | output | 8 | Day of week 0..6 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| clk_fail | output | 1 | Counting halted after total power loss |

## Verification
The assertions check four things on every cycle:
- a power-loss pulse sets the failure flag;
- the flag stays set until a field write clears it, and all fields stay frozen while it is set;
- a minute change without a write lands on second 00, and a date change without a write lands on midnight in the active hour format;
- day of week and date always move together.

Only the bench's scenarios show the exact calendar arithmetic. That covers February in leap and common years, 30-day months, the 12-hour PM toggle, and the year wrap. They also show the prescaler restart after a seconds write and the tick lost under a coincident write. A behavioural reference model compared on every clock covers these cases.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } fld_e;

  localparam logic [7:0] MASK_SEC   = 8'h7F;
  localparam logic [7:0] MASK_MIN   = 8'h7F;
  localparam logic [7:0] MASK_HOUR  = 8'h3F;
  localparam logic [7:0] MASK_DOW   = 8'h07;
  localparam logic [7:0] MASK_DATE  = 8'h3F;
  localparam logic [7:0] MASK_MONTH = 8'h1F;
  localparam logic [7:0] MASK_YEAR  = 8'hFF;

  // Step a BCD byte by one; at or beyond 'last' it returns 'first'.
  function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                          input logic [7:0] last,
                                          input logic [7:0] first);
    if (v >= last)          return first;
    if (v[3:0] >= 4'd9)     return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic ref_en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && ref_en && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) cnt_q <= '0;
    else if (ref_en)               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);
  logic leap;

  // multiple of 4 in BCD: odd tens digit -> units 2 or 6, even -> 0, 4 or 8
  always_comb begin
    if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                        (year[3:0] == 4'd8);
  end

  always_comb begin
    case (month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  logic [7:0] hour_q,
  input  logic       mode_12h,
  output logic [7:0] hour_d,
  output logic       day_carry
);
  logic       pm;
  logic [7:0] h12;

  assign pm  = hour_q[5];
  assign h12 = {3'b000, hour_q[4:0]};

  always_comb begin
    if (!mode_12h) begin
      day_carry = (hour_q >= 8'h23);
      hour_d    = bcd_next(hour_q, 8'h23, 8'h00);
    end else if (h12 == 8'h11) begin
      day_carry = pm;
      hour_d    = {2'b00, ~pm, 5'h12};
    end else if (h12 >= 8'h12) begin
      day_carry = 1'b0;
      hour_d    = {2'b00, pm, 5'h01};
    end else begin
      day_carry = 1'b0;
      hour_d    = {2'b00, pm, 5'(bcd_next(h12, 8'h11, 8'h01))};
    end
  end
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import rtc_cal_pkg::*;
#(
  parameter int REF_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       power_lost,
  input  logic       mode_12h,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       clk_fail
);
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
  logic       fail_q;
  fld_e       sel;
  logic       fld_wr, sec_wr, run, tick, advance;
  logic [7:0] hour_nx, last_date;
  logic       sec_c, min_c, day_c, date_c, month_c;

  assign sel     = fld_e'(wr_addr);
  assign fld_wr  = wr_en && (sel != FLD_NONE);
  assign sec_wr  = fld_wr && (sel == FLD_SEC);
  assign run     = !fail_q;
  assign advance = tick && !fld_wr && !power_lost;

  rtc_prescaler #(.DIV(REF_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(sec_wr),
    .ref_en(ref_en), .tick(tick)
  );

  rtc_hour_step u_hour (
    .hour_q(hour_q), .mode_12h(mode_12h), .hour_d(hour_nx), .day_carry(day_c)
  );

  rtc_month_days u_mdays (
    .month(month_q), .year(year_q), .last_date(last_date)
  );

  assign sec_c   = (sec_q   >= 8'h59);
  assign min_c   = (min_q   >= 8'h59);
  assign date_c  = (date_q  >= last_date);
  assign month_c = (month_q >= 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      dow_q   <= 8'h00;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
      fail_q  <= 1'b1;
    end else if (power_lost) begin
      fail_q <= 1'b1;
    end else if (fld_wr) begin
      fail_q <= 1'b0;
      case (sel)
        FLD_SEC:   sec_q   <= wr_data & MASK_SEC;
        FLD_MIN:   min_q   <= wr_data & MASK_MIN;
        FLD_HOUR:  hour_q  <= wr_data & MASK_HOUR;
        FLD_DOW:   dow_q   <= wr_data & MASK_DOW;
        FLD_DATE:  date_q  <= wr_data & MASK_DATE;
        FLD_MONTH: month_q <= wr_data & MASK_MONTH;
        FLD_YEAR:  year_q  <= wr_data & MASK_YEAR;
        default:   ;
      endcase
    end else if (advance) begin
      sec_q <= bcd_next(sec_q, 8'h59, 8'h00);
      if (sec_c) begin
        min_q <= bcd_next(min_q, 8'h59, 8'h00);
        if (min_c) begin
          hour_q <= hour_nx;
          if (day_c) begin
            dow_q  <= bcd_next(dow_q, 8'h06, 8'h00);
            date_q <= bcd_next(date_q, last_date, 8'h01);
            if (date_c) begin
              month_q <= bcd_next(month_q, 8'h12, 8'h01);
              if (month_c) year_q <= bcd_next(year_q, 8'h99, 8'h00);
            end
          end
        end
      end
    end
  end

  assign sec_o    = sec_q;
  assign min_o    = min_q;
  assign hour_o   = hour_q;
  assign dow_o    = dow_q;
  assign date_o   = date_q;
  assign month_o  = month_q;
  assign year_o   = year_q;
  assign clk_fail = fail_q;
endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       power_lost,
  input logic       mode_12h,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       clk_fail
);
  logic [55:0] fields;
  logic        real_wr;
  assign fields  = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
  assign real_wr = wr_en && (wr_addr != 3'd7);

  // R2
  pwr_fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_lost |=> clk_fail);

  // R2
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !wr_en) |=> $stable(fields));

  // R3
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (real_wr && !power_lost) |=> !clk_fail);

  // R3
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !real_wr) |=> clk_fail);

  // R5
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(min_o) || sec_o == 8'h00));

  // R6
  midnight_24_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !mode_12h) |=> ($stable(date_o) || hour_o == 8'h00));

  // R7
  midnight_12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_12h) |=> ($stable(date_o) || hour_o == 8'h12));

  // R10
  dow_with_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(date_o) == $stable(dow_o)));

  // R1
  always_ff @(posedge clk) begin
    if (rst_n && $past(!rst_n)) begin
      reset_state_chk: assert (clk_fail && month_o == 8'h01 && year_o == 8'h00);
    end
  end
endmodule

bind bcd_cal_clock bcd_cal_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .power_lost(power_lost), .mode_12h(mode_12h),
  .wr_en(wr_en), .wr_addr(wr_addr), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
  .year_o(year_o), .clk_fail(clk_fail)
);

// File: tb/bcd_cal_clock_bench.sv
module bcd_cal_clock_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0, power_lost = 1'b0, mode_12h = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       clk_fail;

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #5 clk = ~clk;

  bcd_cal_clock #(.REF_DIV(DIV)) u_bcd_cal_clock (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .power_lost(power_lost),
    .mode_12h(mode_12h), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .clk_fail(clk_fail)
  );

  // ---------------- behavioural reference model ----------------
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_pc;
  bit m_fail, m_fmt12;

  function automatic int fb(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] tb_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] hour_byte(input int h24, input bit f12);
    int h;
    if (!f12) return tb_bcd(h24);
    h = (h24 % 12 == 0) ? 12 : h24 % 12;
    return tb_bcd(h) | ((h24 >= 12) ? 8'h20 : 8'h00);
  endfunction

  always @(posedge clk) begin
    bit fw, tk;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 0; m_date = 1; m_mon = 1;
      m_yr = 0; m_pc = 0; m_fail = 1; m_fmt12 = 0;
    end else begin
      fw = wr_en && (wr_addr != 3'd7);
      tk = 0;
      if (m_fail) m_pc = 0;
      else if (fw && wr_addr == 3'd0) m_pc = 0;
      else if (ref_en) begin
        if (m_pc == DIV - 1) begin m_pc = 0; tk = 1; end
        else m_pc++;
      end
      if (power_lost) m_fail = 1;
      else if (fw) begin
        m_fail = 0;
        case (wr_addr)
          3'd0: m_sec  = fb(wr_data);
          3'd1: m_min  = fb(wr_data);
          3'd2: begin
            m_fmt12 = mode_12h;
            if (mode_12h) m_hr = (fb({3'b0, wr_data[4:0]}) % 12) + (wr_data[5] ? 12 : 0);
            else          m_hr = fb(wr_data);
          end
          3'd3: m_dow  = fb(wr_data);
          3'd4: m_date = fb(wr_data);
          3'd5: m_mon  = fb(wr_data);
          default: m_yr = fb(wr_data);
        endcase
      end else if (tk) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
              m_hr = 0;
              m_dow = (m_dow + 1) % 7;
              if (m_date >= mdays(m_mon, m_yr)) begin
                m_date = 1; m_mon++;
                if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
              end else m_date++;
            end
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [63:0] act, exp;
    if (rst_n && !finished) begin
      act = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, 7'd0, clk_fail};
      exp = {tb_bcd(m_sec), tb_bcd(m_min), hour_byte(m_hr, m_fmt12), tb_bcd(m_dow),
             tb_bcd(m_date), tb_bcd(m_mon), tb_bcd(m_yr), 7'd0, m_fail};
      n_tests++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s model: actual %h expected %h", cur_req, act, exp);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr_hour(input bit m12, input logic [7:0] d);
    @(posedge clk); #1;
    mode_12h = m12; wr_en = 1'b1; wr_addr = 3'd2; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input bit m12,
                         input logic [7:0] h, input logic [7:0] dt,
                         input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd0, s); wr(3'd1, mi); wr_hour(m12, h);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    chk(clk_fail == 1'b1, "R1", {7'd0, clk_fail}, 8'h01);
    chk(date_o == 8'h01 && month_o == 8'h01, "R1", date_o, 8'h01);
    ref_en = 1'b1;
    cyc(20);
    chk(sec_o == 8'h00, "R1", sec_o, 8'h00);

    // R3: address 7 ignored, flag stays
    cur_req = "R3";
    wr(3'd7, 8'h45);
    cyc(10);
    chk(clk_fail == 1'b1, "R3", {7'd0, clk_fail}, 8'h01);
    chk(sec_o == 8'h00, "R3", sec_o, 8'h00);

    // R3: a write starts the clock; R4: full second after seconds write
    cur_req = "R4";
    wr(3'd0, 8'h10);
    chk(clk_fail == 1'b0, "R3", {7'd0, clk_fail}, 8'h00);
    cyc(3);
    chk(sec_o == 8'h10, "R4", sec_o, 8'h10);
    cyc(1);
    chk(sec_o == 8'h11, "R4", sec_o, 8'h11);
    cyc(6);
    wr(3'd0, 8'h20);   // mid-prescale restart
    cyc(3);
    chk(sec_o == 8'h20, "R4", sec_o, 8'h20);
    cyc(1);
    chk(sec_o == 8'h21, "R4", sec_o, 8'h21);

    // R4: gappy reference enable
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1; ref_en = (i % 3 != 0);
    end
    ref_en = 1'b1;

    // R5, R6, R10: year end rollover, 24-hour
    cur_req = "R10";
    wr(3'd3, 8'h06);
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h31, 8'h12, 8'h99);
    cyc(150);
    chk(year_o == 8'h00, "R10", year_o, 8'h00);
    chk(month_o == 8'h01 && date_o == 8'h01, "R10", date_o, 8'h01);
    chk(dow_o == 8'h00, "R10", dow_o, 8'h00);
    chk(hour_o == 8'h00 && min_o == 8'h00, "R6", hour_o, 8'h00);

    // R9: leap February
    cur_req = "R9";
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h28, 8'h02, 8'h24);
    cyc(150);
    chk(date_o == 8'h29 && month_o == 8'h02, "R9", date_o, 8'h29);
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h29, 8'h02, 8'h12);
    cyc(150);
    chk(date_o == 8'h01 && month_o == 8'h03, "R9", month_o, 8'h03);
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h28, 8'h02, 8'h23);
    cyc(150);
    chk(date_o == 8'h01 && month_o == 8'h03, "R9", date_o, 8'h01);

    // R8: 30-day months
    cur_req = "R8";
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h30, 8'h04, 8'h25);
    cyc(150);
    chk(date_o == 8'h01 && month_o == 8'h05, "R8", month_o, 8'h05);
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h30, 8'h11, 8'h25);
    cyc(150);
    chk(date_o == 8'h01 && month_o == 8'h12, "R8", month_o, 8'h12);

    // R7: 12-hour format
    cur_req = "R7";
    set_all(8'h50, 8'h59, 1'b1, 8'h11, 8'h15, 8'h06, 8'h25);
    cyc(150);
    chk(hour_o == 8'h32, "R7", hour_o, 8'h32);
    wr(3'd1, 8'h59); wr(3'd0, 8'h50);
    cyc(150);
    chk(hour_o == 8'h21, "R7", hour_o, 8'h21);
    set_all(8'h50, 8'h59, 1'b1, 8'h31, 8'h15, 8'h06, 8'h25);
    cyc(150);
    chk(hour_o == 8'h12 && date_o == 8'h16, "R7", hour_o, 8'h12);

    // R6: 24-hour midnight
    cur_req = "R6";
    set_all(8'h50, 8'h59, 1'b0, 8'h23, 8'h15, 8'h06, 8'h25);
    cyc(150);
    chk(hour_o == 8'h00 && date_o == 8'h16, "R6", hour_o, 8'h00);

    // R11: writes landing on assorted prescaler phases
    cur_req = "R11";
    for (int i = 0; i < 12; i++) begin
      wr(3'd1, 8'h30);
      cyc(i % 4);
    end
    chk(min_o == 8'h30, "R11", min_o, 8'h30);

    // R2: power loss freezes, and wins over a coincident write
    cur_req = "R2";
    @(posedge clk); #1; power_lost = 1'b1;
    @(posedge clk); #1; power_lost = 1'b0;
    chk(clk_fail == 1'b1, "R2", {7'd0, clk_fail}, 8'h01);
    cyc(40);
    @(posedge clk); #1; power_lost = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h09;
    @(posedge clk); #1; power_lost = 1'b0; wr_en = 1'b0;
    chk(clk_fail == 1'b1 && month_o == 8'h06, "R2", month_o, 8'h06);
    cyc(20);
    wr(3'd4, 8'h20);
    chk(clk_fail == 1'b0 && date_o == 8'h20, "R3", date_o, 8'h20);
    cyc(40);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule